// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a simple host request stream and one 16-bit SDRAM device with four banks. After reset it raises the clock enable and writes the device's mode register once. It then takes single-word read and write requests, each carrying a flat word address. Every request becomes a closed-page access: the controller opens the row, waits the row-to-column delay, and issues a READ or WRITE with auto precharge. Read data is captured from the device a fixed number of cycles after the READ and returned to the host.

A free-running interval counter asks for an AUTO REFRESH every `REF_INTERVAL` clocks. The default of 1560 spreads 4,096 refreshes over 64 ms at roughly 100 MHz. A pending refresh is served as soon as the current access has finished, ahead of any waiting request. All timing gaps (`T_RCD`, `T_RP`, `T_WR`, `T_RFC`, `T_MRD`, `CAS_LAT`) are parameters in clock cycles, and every command slot between them carries NOP.

Request back-pressure: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle and no refresh is waiting. The host must hold `req_valid`, `req_write`, `req_addr` and `req_wdata` stable until the transfer. The read response has no back-pressure: `rsp_valid` is a one-cycle pulse that the host must take.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is active, `sd_cke` is 0 and the pins carry NOP. After reset, `sd_cke` rises and stays high. The first command is LOAD MODE with `sd_ba` = 0, A[11:7] = 0, A[6:4] = `CAS_LAT`, A3 = 0 (sequential) and A[2:0] = 000 (burst of one). It is issued exactly once.
- R2: Commands on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} use these codes: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, AUTO REFRESH 0001, LOAD MODE 0000. No other code appears.
- R3: The flat address is split as bank = addr[22:21], row = addr[20:9] and column = addr[8:0]. ACTIVE carries the bank on `sd_ba` and the row on A[11:0]. READ and WRITE carry the same bank and the column on A[8:0], with A10 = 1 for auto precharge and A9 = A11 = 0.
- R4: READ or WRITE follows its ACTIVE by exactly `T_RCD` cycles.
- R5: The next non-NOP command comes no sooner than a minimum gap after the previous one: `T_MRD` after LOAD MODE, `T_RFC` after AUTO REFRESH, `CAS_LAT`+`T_RP` after READ, `T_WR`+`T_RP` after WRITE.
- R6: `sd_dq_oe` is high in, and only in, the cycle that carries WRITE, with the request's data on `sd_dq_out`.
- R7: `rsp_valid` pulses exactly `CAS_LAT`+1 cycles after the cycle carrying READ. In that pulse `rsp_data` holds the word the device drove on `sd_dq_in`.
- R8: AUTO REFRESH is issued every `REF_INTERVAL` cycles while idle. Under continuous requests each refresh is delayed by at most one access, so refreshes are never starved.
- R9: When `req_valid` and `req_ready` are both high at an edge, the request is accepted and its ACTIVE is on the pins in the next cycle. Each request yields exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Flat word address {bank,row,column} |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data pulse |
| rsp_data | output | 16 | Read data |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed row/column/mode address |
| sd_dq_out | output | 16 | Data toward the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from the device |

## Verification
The properties assume that the host keeps its request fields stable while `req_valid` waits for `req_ready`. They also assume that the timing parameters are at least 1 and that `CAS_LAT` lies between 1 and 3. The latency and data properties further assume that the device drives `sd_dq_in` in the capture cycle. The stimulus changes inputs only on falling clock edges and holds each request until it is accepted. Its memory model registers commands on rising edges and returns read data through a delay line exactly `CAS_LAT` stages deep.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Pin code {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_WAKE,
    ST_MODE,
    ST_IDLE,
    ST_ACT_WAIT,
    ST_GAP
  } sdr_state_e;

  // Mode word: reserved fields zero, write bursts follow burst length,
  // sequential order, burst length one, latency in [6:4].
  function automatic logic [11:0] mode_word(input int unsigned cas_lat);
    logic [11:0] w;
    w      = 12'b0;
    w[6:4] = cas_lat[2:0];
    return w;
  endfunction

endpackage

// File: rtl/sdr_addr_split.sv
module sdr_addr_split #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] flat_addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  // bank in the top bits, column in the bottom bits
  assign bank = flat_addr[ADDR_W-1 -: BANK_W];
  assign row  = flat_addr[COL_W +: ROW_W];
  assign col  = flat_addr[COL_W-1:0];
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int REF_INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_pending
);
  localparam int TW = $clog2(REF_INTERVAL + 1);

  logic [TW-1:0] tick_cnt;
  logic          tick;

  assign tick = (tick_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= TW'(REF_INTERVAL - 1);
    end else if (tick) begin
      tick_cnt <= TW'(REF_INTERVAL - 1);
    end else begin
      tick_cnt <= tick_cnt - 1'b1;
    end
  end

  // A new tick wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pending <= 1'b0;
    end else if (tick) begin
      ref_pending <= 1'b1;
    end else if (ref_ack) begin
      ref_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int DQ_W    = 16,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int T_WR    = 2,
  parameter int T_RFC   = 4,
  parameter int T_MRD   = 2,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_pending,
  output logic              ref_ack,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DQ_W-1:0]   req_wdata,
  output sdr_cmd_e          cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  a,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              cke,
  output logic              rd_issue
);
  localparam int GAP_RD  = CAS_LAT + T_RP;
  localparam int GAP_WR  = T_WR + T_RP;
  localparam int GAP_A   = (GAP_RD > GAP_WR) ? GAP_RD : GAP_WR;
  localparam int GAP_B   = (T_RFC > T_MRD) ? T_RFC : T_MRD;
  localparam int GAP_C   = (GAP_A > GAP_B) ? GAP_A : GAP_B;
  localparam int GAP_MAX = (GAP_C > T_RCD) ? GAP_C : T_RCD;
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam int AP_BIT  = 10;

  sdr_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              lat_write;
  logic [COL_W-1:0]  lat_col;
  logic [DQ_W-1:0]   lat_wdata;

  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign ref_ack   = (state == ST_IDLE) && ref_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAKE;
      cnt       <= '0;
      cmd       <= CMD_NOP;
      ba        <= '0;
      a         <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      cke       <= 1'b0;
      rd_issue  <= 1'b0;
      lat_write <= 1'b0;
      lat_col   <= '0;
      lat_wdata <= '0;
    end else begin
      cmd      <= CMD_NOP;
      dq_oe    <= 1'b0;
      rd_issue <= 1'b0;
      unique case (state)
        ST_WAKE: begin
          cke   <= 1'b1;
          state <= ST_MODE;
        end
        ST_MODE: begin
          cmd   <= CMD_LMR;
          ba    <= '0;
          a     <= ROW_W'(mode_word(CAS_LAT));
          cnt   <= CNT_W'(T_MRD - 1);
          state <= ST_GAP;
        end
        ST_IDLE: begin
          if (ref_pending) begin
            cmd   <= CMD_REF;
            cnt   <= CNT_W'(T_RFC - 1);
            state <= ST_GAP;
          end else if (req_valid) begin
            cmd       <= CMD_ACT;
            ba        <= req_bank;
            a         <= req_row;
            lat_write <= req_write;
            lat_col   <= req_col;
            lat_wdata <= req_wdata;
            cnt       <= CNT_W'(T_RCD - 1);
            state     <= ST_ACT_WAIT;
          end
        end
        ST_ACT_WAIT: begin
          if (cnt == '0) begin
            a              <= '0;
            a[COL_W-1:0]   <= lat_col;
            a[AP_BIT]      <= 1'b1;
            state          <= ST_GAP;
            if (lat_write) begin
              cmd    <= CMD_WR;
              dq_oe  <= 1'b1;
              dq_out <= lat_wdata;
              cnt    <= CNT_W'(GAP_WR - 1);
            end else begin
              cmd      <= CMD_RD;
              rd_issue <= 1'b1;
              cnt      <= CNT_W'(GAP_RD - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int CAS_LAT = 2,
  parameter int DQ_W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_issue,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rsp_valid,
  output logic [DQ_W-1:0] rsp_data
);
  logic [CAS_LAT-1:0] pipe;

  generate
    if (CAS_LAT == 1) begin : g_lat1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= rd_issue;
      end
    end else begin : g_latn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[CAS_LAT-2:0], rd_issue};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= pipe[CAS_LAT-1];
      if (pipe[CAS_LAT-1]) rsp_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int DQ_W         = 16,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_WR         = 2,
  parameter int T_RFC        = 4,
  parameter int T_MRD        = 2,
  parameter int CAS_LAT      = 2,
  parameter int REF_INTERVAL = 1560,
  localparam int ADDR_W      = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_data,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [DQ_W-1:0]   sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DQ_W-1:0]   sd_dq_in
);
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic              ref_pending;
  logic              ref_ack;
  logic              rd_issue;
  sdr_cmd_e          cmd;

  sdr_addr_split #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_split (
    .flat_addr(req_addr), .bank(req_bank), .row(req_row), .col(req_col)
  );

  sdr_refresh_timer #(
    .REF_INTERVAL(REF_INTERVAL)
  ) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_pending(ref_pending)
  );

  sdr_cmd_fsm #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .CAS_LAT(CAS_LAT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ref_pending(ref_pending), .ref_ack(ref_ack),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata),
    .cmd(cmd), .ba(sd_ba), .a(sd_a), .dq_out(sd_dq_out), .dq_oe(sd_dq_oe),
    .cke(sd_cke), .rd_issue(rd_issue)
  );

  sdr_rd_capture #(
    .CAS_LAT(CAS_LAT), .DQ_W(DQ_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .dq_in(sd_dq_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
endmodule

// File: rtl/sdram_seq_ctrl_chk.sv
module sdram_seq_ctrl_chk
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int T_RCD   = 2,
  parameter int T_RP    = 2,
  parameter int T_WR    = 2,
  parameter int T_RFC   = 4,
  parameter int T_MRD   = 2,
  parameter int CAS_LAT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BANK_W-1:0] sd_ba,
  input logic [ROW_W-1:0]  sd_a,
  input logic              sd_dq_oe
);
  logic [3:0] pin_cmd;
  logic [7:0] since_act;
  logic [7:0] since_cmd;
  logic [3:0] last_cmd;
  logic       is_rw;

  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_rw   = (pin_cmd == CMD_RD) || (pin_cmd == CMD_WR);

  function automatic int min_gap(input logic [3:0] c);
    case (c)
      CMD_LMR: return T_MRD;
      CMD_REF: return T_RFC;
      CMD_RD:  return CAS_LAT + T_RP;
      CMD_WR:  return T_WR + T_RP;
      CMD_ACT: return T_RCD;
      default: return 0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 8'hFF;
      since_cmd <= 8'hFF;
      last_cmd  <= CMD_NOP;
    end else begin
      if (pin_cmd == CMD_ACT)   since_act <= 8'd1;
      else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
      if (pin_cmd != CMD_NOP) begin
        since_cmd <= 8'd1;
        last_cmd  <= pin_cmd;
      end else if (since_cmd != 8'hFF) begin
        since_cmd <= since_cmd + 8'd1;
      end
    end
  end

  // R1
  mode_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_LMR) |-> (sd_ba == '0 && sd_a == ROW_W'(mode_word(CAS_LAT))));

  // R1
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_cke |=> sd_cke);

  // R2
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd == CMD_NOP || pin_cmd == CMD_ACT || pin_cmd == CMD_RD ||
     pin_cmd == CMD_WR || pin_cmd == CMD_REF || pin_cmd == CMD_LMR));

  // R3
  auto_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (sd_a[10] && !sd_a[11] && !sd_a[9]));

  // R4
  act_to_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (since_act == 8'(T_RCD)));

  // R5
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd != CMD_NOP) |-> (int'(since_cmd) >= min_gap(last_cmd)));

  // R6
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe == (pin_cmd == CMD_WR));

  // R7
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(pin_cmd == CMD_RD, CAS_LAT + 1));

  // R9
  accept_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (pin_cmd == CMD_ACT));
endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP),
  .T_WR(T_WR), .T_RFC(T_RFC), .T_MRD(T_MRD), .CAS_LAT(CAS_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_oe(sd_dq_oe)
);

// File: tb/sdram_seq_ctrl_bench.sv
module sdram_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_RP = 2, T_WR = 2, T_RFC = 4, T_MRD = 2;
  localparam int CL = 2;
  localparam int REF_IV = 400;
  localparam int GAP_RD = CL + T_RP;
  localparam int GAP_WR = T_WR + T_RP;
  localparam int SLACK = T_RCD + ((GAP_RD > GAP_WR) ? GAP_RD : GAP_WR) + 2;
  localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_ACT = 4'b0011,
                         C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [15:0] rsp_data, sd_dq_out, sd_dq_in;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;
  logic        sd_dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_seq_ctrl #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .CAS_LAT(CL), .REF_INTERVAL(REF_IV)
  ) u_sdram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  logic [3:0] pins;
  assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // ---------------- device model and pin monitor ----------------
  logic [15:0] mem [logic [22:0]];
  logic [11:0] open_row [4];
  logic [15:0] dly [3];
  int          cyc = 0;
  int          bad_oe = 0;
  int          ev_cyc[$];
  logic [3:0]  ev_cmd[$];
  logic [1:0]  ev_ba[$];
  logic [11:0] ev_a[$];
  int          rd_cyc_q[$];
  int          rsp_cyc_q[$];
  logic [15:0] rsp_q[$];

  assign sd_dq_in = dly[CL-1];

  always @(posedge clk) begin
    logic [22:0] key;
    logic [15:0] rdv;
    cyc = cyc + 1;
    rdv = 16'h0000;
    if (rst_n) begin
      if (pins != C_NOP) begin
        ev_cyc.push_back(cyc); ev_cmd.push_back(pins);
        ev_ba.push_back(sd_ba); ev_a.push_back(sd_a);
      end
      if (sd_dq_oe != (pins == C_WR)) bad_oe++;
      key = {sd_ba, open_row[sd_ba], sd_a[8:0]};
      if (pins == C_ACT) open_row[sd_ba] = sd_a;
      if (pins == C_WR) mem[key] = sd_dq_oe ? sd_dq_out : 16'hBAD0;
      if (pins == C_RD) begin
        rd_cyc_q.push_back(cyc);
        rdv = mem.exists(key) ? mem[key] : 16'hDEAD;
      end
      if (rsp_valid) begin
        rsp_q.push_back(rsp_data); rsp_cyc_q.push_back(cyc);
      end
    end
    dly[0] <= rdv;
    dly[1] <= dly[0];
    dly[2] <= dly[1];
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] shadow [logic [22:0]];
  logic [15:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // R9: one request through the handshake; ACTIVE appears in the next cycle
  task automatic do_req(input bit wr, input logic [22:0] ad, input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(pins == C_ACT, "R9", "cmd after accept", pins, C_ACT);
    if (wr) shadow[ad] = wd;
    else exp_q.push_back(shadow.exists(ad) ? shadow[ad] : 16'hDEAD);
  endtask

  task automatic drain_rsps(input string req);
    repeat (20) @(negedge clk);
    chk(rsp_q.size() == exp_q.size(), req, "response count", rsp_q.size(), exp_q.size());
    while (rsp_q.size() > 0 && exp_q.size() > 0) begin
      logic [15:0] got, want;
      got = rsp_q.pop_front(); want = exp_q.pop_front();
      chk(got == want, req, "read data", got, want);
    end
    rsp_q.delete(); exp_q.delete();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(sd_cke == 1'b0, "R1", "cke in reset", sd_cke, 0);
    chk(pins == C_NOP, "R1", "cmd in reset", pins, C_NOP);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(sd_cke == 1'b1, "R1", "cke after reset", sd_cke, 1);
    chk(ev_cmd.size() > 0 && ev_cmd[0] == C_LMR, "R1", "first command",
        ev_cmd.size() > 0 ? ev_cmd[0] : 4'hF, C_LMR);
    if (ev_cmd.size() > 0) begin
      chk(ev_ba[0] == 2'b00, "R1", "mode bank", ev_ba[0], 0);
      chk(ev_a[0] == 12'(CL << 4), "R1", "mode word", ev_a[0], CL << 4);
    end
  endtask

  task automatic t_single();
    int i0, ia;
    logic [22:0] ad;
    ad = {2'd2, 12'hA5C, 9'h1B3};
    i0 = ev_cmd.size();
    do_req(1'b1, ad, 16'h3C5A);
    repeat (12) @(negedge clk);
    ia = -1;
    for (int i = i0; i < ev_cmd.size(); i++) if (ia < 0 && ev_cmd[i] == C_ACT) ia = i;
    chk(ia >= 0 && ia + 1 < ev_cmd.size(), "R3", "write access seen", ia, i0);
    if (ia >= 0 && ia + 1 < ev_cmd.size()) begin
      chk(ev_ba[ia] == 2'd2, "R3", "ACT bank", ev_ba[ia], 2);
      chk(ev_a[ia] == 12'hA5C, "R3", "ACT row", ev_a[ia], 12'hA5C);
      chk(ev_cmd[ia+1] == C_WR, "R2", "WRITE code", ev_cmd[ia+1], C_WR);
      chk(ev_a[ia+1] == 12'h5B3, "R3", "WRITE column and A10", ev_a[ia+1], 12'h5B3);
      chk(ev_ba[ia+1] == 2'd2, "R3", "WRITE bank", ev_ba[ia+1], 2);
      chk(ev_cyc[ia+1] - ev_cyc[ia] == T_RCD, "R4", "ACT to WRITE",
          ev_cyc[ia+1] - ev_cyc[ia], T_RCD);
    end
    do_req(1'b0, ad, 16'h0);
    repeat (12) @(negedge clk);
    chk(rd_cyc_q.size() > 0 && rsp_cyc_q.size() > 0 &&
        rsp_cyc_q[$] - rd_cyc_q[$] == CL + 1, "R7", "READ to response cycles",
        (rsp_cyc_q.size() > 0 && rd_cyc_q.size() > 0) ? rsp_cyc_q[$] - rd_cyc_q[$] : -1,
        CL + 1);
    drain_rsps("R6");
  endtask

  task automatic t_patterns();
    logic [22:0] pat [8];
    pat[0] = 23'h000000; pat[1] = 23'h7FFFFF; pat[2] = 23'h0001FF; pat[3] = 23'h600000;
    pat[4] = 23'h555555; pat[5] = 23'h2AAAAA; pat[6] = 23'h1FFE00; pat[7] = 23'h400100;
    for (int i = 0; i < 8; i++) do_req(1'b1, pat[i], 16'h1000 + 16'(i * 16'h0111));
    for (int i = 7; i >= 0; i--) do_req(1'b0, pat[i], 16'h0);
    do_req(1'b0, 23'h123456, 16'h0); // never written
    drain_rsps("R3");
  endtask

  task automatic t_refresh_idle();
    int i0, nref, last, bad;
    repeat (20) @(negedge clk);
    i0 = ev_cmd.size();
    repeat (3 * REF_IV + 10) @(negedge clk);
    nref = 0; last = -1; bad = 0;
    for (int i = i0; i < ev_cmd.size(); i++) begin
      if (ev_cmd[i] == C_REF) begin
        if (last >= 0 && ev_cyc[i] - last != REF_IV) bad++;
        last = ev_cyc[i]; nref++;
      end
    end
    chk(nref >= 3, "R8", "idle refresh count", nref, 3);
    chk(bad == 0, "R8", "idle refresh interval errors", bad, 0);
  endtask

  task automatic t_refresh_busy();
    int i0, nref, last, worst, c0;
    i0 = ev_cmd.size();
    c0 = cyc;
    while (cyc - c0 < 3 * REF_IV) begin
      do_req(1'b1, 23'(cyc * 37), 16'(cyc));
      do_req(1'b0, 23'(cyc * 11), 16'h0);
    end
    nref = 0; last = -1; worst = 0;
    for (int i = i0; i < ev_cmd.size(); i++) begin
      if (ev_cmd[i] == C_REF) begin
        if (last >= 0 && ev_cyc[i] - last > worst) worst = ev_cyc[i] - last;
        last = ev_cyc[i]; nref++;
      end
    end
    chk(nref >= 2, "R8", "refreshes under load", nref, 2);
    chk(worst <= REF_IV + SLACK, "R8", "longest refresh interval", worst, REF_IV + SLACK);
    drain_rsps("R7");
  endtask

  task automatic t_pin_rules();
    int bad, nlmr;
    bad = 0; nlmr = 0;
    for (int i = 0; i < ev_cmd.size(); i++) begin
      int need;
      if (ev_cmd[i] == C_LMR) nlmr++;
      if (i > 0) begin
        case (ev_cmd[i-1])
          C_LMR: need = T_MRD;
          C_REF: need = T_RFC;
          C_RD:  need = GAP_RD;
          C_WR:  need = GAP_WR;
          default: need = T_RCD;
        endcase
        if (ev_cyc[i] - ev_cyc[i-1] < need) bad++;
      end
    end
    chk(bad == 0, "R5", "command gap violations", bad, 0);
    chk(nlmr == 1, "R1", "LOAD MODE count", nlmr, 1);
    chk(bad_oe == 0, "R6", "cycles with oe not matching WRITE", bad_oe, 0);
  endtask

  initial begin
    for (int b = 0; b < 4; b++) open_row[b] = '0;
    for (int s = 0; s < 3; s++) dly[s] = '0;
    t_reset();
    t_single();
    t_patterns();
    t_refresh_idle();
    t_refresh_busy();
    t_pin_rules();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end
endmodule